// File: doc/BRIEF.md
# Prioritized Peripheral Interrupt Controller

This controller gathers level-sensitive interrupt requests from four peripheral sources: two PCI request lines and two timer channels. Each source has a 4-bit priority level held in one priority register and a block bit held in a mask register. The controller picks the pending source that is not blocked and has the highest level. It registers that source's index and level, and raises an interrupt line when the level is above the level the CPU is running at.

Software uses a small synchronous bus with four word addresses. Address 0 holds the priority fields. Address 1 is a read-only view of the raw request lines. Address 2 sets mask bits. Address 3 clears mask bits. Both mask addresses read back the current mask. Read data is registered, so it appears one cycle after the address is presented. CPU exception entry and vector fetch are handled elsewhere.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is high, every register clears on the clock edge. After that edge, read data, the interrupt line, the winning level and the winning index are all zero.
- R2: The priority register is at address 0 and has these fields: PCI source 0 in bits 3:0, PCI source 1 in bits 7:4, timer channel 3 in bits 11:8 and timer channel 4 in bits 15:12. Bits 31:16 ignore writes and read as zero.
- R3: Address 1 reads the request lines as sampled one cycle earlier. Bits 0 and 1 are the PCI sources, bits 2 and 3 are timer channels 3 and 4, and all other bits are zero. The value does not depend on priority or mask settings, and writes to address 1 have no effect.
- R4: Writing to address 2 sets every mask bit whose data bit is 1. Zero data bits leave the mask unchanged. Address 2 and address 3 both read the mask in bits 3:0.
- R5: Writing to address 3 clears every mask bit whose data bit is 1. Zero data bits leave the mask unchanged.
- R6: A source whose priority field is 0 never wins arbitration.
- R7: A source whose mask bit is 1 never wins arbitration.
- R8: Among sources that are requesting, not masked and have a nonzero level, the highest level wins. When levels are equal, the lower bit position wins.
- R9: The interrupt line is high only when the winning level is strictly greater than the CPU level input.
- R10: The level, index and interrupt outputs update one clock edge after their inputs change. When no source qualifies, the level and index are zero and the interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 2 | Register word address |
| bus_wen_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| req_i | input | 4 | Level-sensitive request lines (PCI 0, PCI 1, timer 3, timer 4) |
| cpu_lvl_i | input | 4 | Current CPU interrupt level |
| irq_o | output | 1 | Interrupt to the CPU |
| irq_level_o | output | 4 | Level of the winning source |
| irq_src_o | output | 2 | Index of the winning source |

## Verification
The assertions assume that the request lines and the CPU level input are stable in the cycle before each clock edge. They also assume that the winner reported after an edge is judged against the mask and request values present before that edge. The bench drives all inputs on the falling clock edge, so every value is settled well before the rising edge that samples it. The bench changes priority and mask settings only through bus writes, and these complete at least one edge before the requests under test are applied. As a result, each arbitration result depends on a single, well-defined set of configuration and request values.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int DATA_W = 32;
  localparam int LVL_W  = 4;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_PRIO = 2'd0,
    ADR_STAT = 2'd1,
    ADR_MSET = 2'd2,
    ADR_MCLR = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wen_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [NUM_SRC-1:0]       req_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [NUM_SRC*LVL_W-1:0] prio_o,
  output logic [NUM_SRC-1:0]       mask_o
);
  localparam int PW = NUM_SRC * LVL_W;

  logic [PW-1:0]      prio_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] stat_q;
  logic [DATA_W-1:0]  rd_mux;

  // Priority and mask registers; only the implemented field bits are stored.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prio_q <= '0;
      mask_q <= '0;
    end else if (wen_i) begin
      unique case (reg_addr_e'(addr_i))
        ADR_PRIO: prio_q <= wdata_i[PW-1:0];
        ADR_MSET: mask_q <= mask_q | wdata_i[NUM_SRC-1:0];
        ADR_MCLR: mask_q <= mask_q & ~wdata_i[NUM_SRC-1:0];
        default:  ;
      endcase
    end
  end

  // Raw request snapshot, independent of priority and mask.
  always_ff @(posedge clk_i) begin
    if (rst_i) stat_q <= '0;
    else       stat_q <= req_i;
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_e'(addr_i))
      ADR_PRIO: rd_mux[PW-1:0]      = prio_q;
      ADR_STAT: rd_mux[NUM_SRC-1:0] = stat_q;
      ADR_MSET,
      ADR_MCLR: rd_mux[NUM_SRC-1:0] = mask_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_o <= '0;
    else       rdata_o <= rd_mux;
  end

  assign prio_o = prio_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC-1:0]       mask_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  output logic [LVL_W-1:0]         win_lvl_o,
  output logic [SRC_W-1:0]         win_idx_o
);
  logic [LVL_W-1:0] eff_lvl [NUM_SRC];

  // A source competes with its level only when requesting and unmasked;
  // otherwise it offers level zero, which can never win.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_field
    assign eff_lvl[g] = (req_i[g] && !mask_i[g]) ? prio_i[g*LVL_W +: LVL_W] : '0;
  end

  // Strict comparison keeps the earlier (lower) index on ties.
  always_comb begin
    win_lvl_o = '0;
    win_idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eff_lvl[i] > win_lvl_o) begin
        win_lvl_o = eff_lvl[i];
        win_idx_o = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_outreg.sv
module prio_irq_outreg
  import prio_irq_pkg::*;
#(
  parameter int SRC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [LVL_W-1:0] win_lvl_i,
  input  logic [SRC_W-1:0] win_idx_i,
  input  logic [LVL_W-1:0] cpu_lvl_i,
  output logic             irq_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [SRC_W-1:0] idx_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_o <= 1'b0;
      lvl_o <= '0;
      idx_o <= '0;
    end else begin
      irq_o <= (win_lvl_i > cpu_lvl_i);
      lvl_o <= win_lvl_i;
      idx_o <= win_idx_i;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wen_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  input  logic [NUM_SRC-1:0]   req_i,
  input  logic [LVL_W-1:0]     cpu_lvl_i,
  output logic                 irq_o,
  output logic [LVL_W-1:0]     irq_level_o,
  output logic [SRC_W-1:0]     irq_src_o
);
  logic [NUM_SRC*LVL_W-1:0] prio_w;
  logic [NUM_SRC-1:0]       mask_w;
  logic [LVL_W-1:0]         win_lvl_w;
  logic [SRC_W-1:0]         win_idx_w;

  prio_irq_regs #(.NUM_SRC(NUM_SRC)) regs_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .addr_i  (bus_addr_i),
    .wen_i   (bus_wen_i),
    .wdata_i (bus_wdata_i),
    .req_i   (req_i),
    .rdata_o (bus_rdata_o),
    .prio_o  (prio_w),
    .mask_o  (mask_w)
  );

  prio_irq_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
    .req_i     (req_i),
    .mask_i    (mask_w),
    .prio_i    (prio_w),
    .win_lvl_o (win_lvl_w),
    .win_idx_o (win_idx_w)
  );

  prio_irq_outreg #(.SRC_W(SRC_W)) out_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .win_lvl_i (win_lvl_w),
    .win_idx_i (win_idx_w),
    .cpu_lvl_i (cpu_lvl_i),
    .irq_o     (irq_o),
    .lvl_o     (irq_level_o),
    .idx_o     (irq_src_o)
  );
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic [NUM_SRC-1:0] req_i,
  input logic [NUM_SRC-1:0] mask_i,
  input logic [LVL_W-1:0]   cpu_lvl_i,
  input logic               irq_o,
  input logic [LVL_W-1:0]   irq_level_o,
  input logic [SRC_W-1:0]   irq_src_o,
  input logic [DATA_W-1:0]  bus_rdata_o
);
  logic [NUM_SRC-1:0] req_d, mask_d;
  logic [LVL_W-1:0]   cpu_d;

  always_ff @(posedge clk_i) begin
    req_d  <= req_i;
    mask_d <= mask_i;
    cpu_d  <= cpu_lvl_i;
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (!irq_o && irq_level_o == '0 && irq_src_o == '0 && bus_rdata_o == '0));

  assert_winner_unmasked_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_level_o != '0) |-> !mask_d[irq_src_o]);

  assert_winner_requesting_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_level_o != '0) |-> req_d[irq_src_o]);

  assert_irq_above_cpu_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> (irq_level_o > cpu_d));

  assert_idle_outputs_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_level_o == '0) |-> (!irq_o && irq_src_o == '0));

  assert_no_request_quiet_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_d == '0) |-> (irq_level_o == '0));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .req_i       (req_i),
  .mask_i      (mask_w),
  .cpu_lvl_i   (cpu_lvl_i),
  .irq_o       (irq_o),
  .irq_level_o (irq_level_o),
  .irq_src_o   (irq_src_o),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  addr;
  logic        wen;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  req;
  logic [3:0]  cpu;
  logic        irq;
  logic [3:0]  lvl;
  logic [1:0]  src;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] m_prio = '0;
  logic [3:0]  m_mask = '0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .bus_addr_i(addr), .bus_wen_i(wen),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .req_i(req), .cpu_lvl_i(cpu),
    .irq_o(irq), .irq_level_o(lvl), .irq_src_o(src)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  // Expected {irq, level, index} from the requirements.
  function automatic logic [6:0] model(input logic [3:0] r, input logic [3:0] m,
                                       input logic [15:0] p, input logic [3:0] c);
    logic [3:0] bl = '0;
    logic [1:0] bi = '0;
    for (int i = 0; i < 4; i++) begin
      logic [3:0] f = p[i*4 +: 4];
      if (r[i] && !m[i] && f != 0 && f > bl) begin bl = f; bi = 2'(i); end
    end
    return {bl > c, bl, bi};
  endfunction

  task automatic apply_and_check(input string rq, input logic [3:0] r, input logic [3:0] c);
    logic [6:0] e;
    @(negedge clk);
    req = r; cpu = c;
    @(negedge clk);
    e = model(r, m_mask, m_prio, c);
    check(rq, {25'd0, irq, lvl, src}, {25'd0, e});
  endtask

  initial begin
    logic [31:0] rv;
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; addr = '0; wen = 1'b0; wdata = '0; req = '0; cpu = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rdata", rdata, 32'h0);
    check("R1 outputs", {25'd0, irq, lvl, src}, 32'h0);
    rst = 1'b0;

    // R2: reserved bits read zero, field placement
    bus_wr(2'd0, 32'hFFFF_FFFF); m_prio = 16'hFFFF;
    bus_rd(2'd0, rv);
    check("R2 reserved", rv, 32'h0000_FFFF);
    bus_wr(2'd0, 32'h0000_4321); m_prio = 16'h4321;
    bus_rd(2'd0, rv);
    check("R2 readback", rv, 32'h0000_4321);
    apply_and_check("R2 R8 timer ch4 highest", 4'hF, 4'h0);
    check("R8 src", {30'd0, src}, 32'd3);

    // R8 tie goes to lowest index
    bus_wr(2'd0, 32'h0000_5555); m_prio = 16'h5555;
    apply_and_check("R8 tie", 4'b1110, 4'h0);
    check("R8 tie idx", {30'd0, src}, 32'd1);

    // R6: level zero never wins
    bus_wr(2'd0, 32'h0000_0F00); m_prio = 16'h0F00;
    apply_and_check("R6 zero level", 4'b1011, 4'h0);
    check("R6 no win", {28'd0, lvl}, 32'd0);

    // R9 strict compare
    bus_wr(2'd0, 32'h0000_0005); m_prio = 16'h0005;
    apply_and_check("R9 equal", 4'b0001, 4'h5);
    check("R9 no irq", {31'd0, irq}, 32'd0);
    apply_and_check("R9 above", 4'b0001, 4'h4);
    check("R9 irq", {31'd0, irq}, 32'd1);

    // R10 registered latency
    apply_and_check("R10 idle", 4'b0000, 4'h0);
    @(negedge clk); req = 4'b0001;
    #1 check("R10 before edge", {28'd0, lvl}, 32'd0);
    @(negedge clk);
    check("R10 after edge", {28'd0, lvl}, 32'd5);

    // R4 / R5 mask set and clear
    bus_wr(2'd2, 32'h0000_000F); m_mask = 4'hF;
    bus_rd(2'd2, rv); check("R4 set", rv, 32'hF);
    bus_wr(2'd2, 32'h0);
    bus_rd(2'd3, rv); check("R4 zero write", rv, 32'hF);
    apply_and_check("R7 masked", 4'b0001, 4'h0);
    bus_wr(2'd3, 32'h0000_0005); m_mask = 4'hA;
    bus_rd(2'd2, rv); check("R5 clear", rv, 32'hA);
    bus_wr(2'd3, 32'h0);
    bus_rd(2'd2, rv); check("R5 zero write", rv, 32'hA);

    // R3 status shows raw requests despite mask/level 0, write ignored
    @(negedge clk); req = 4'b1010;
    bus_wr(2'd1, 32'hFFFF_FFFF);
    bus_rd(2'd1, rv); check("R3 raw status", rv, 32'h0000_000A);

    // Random phase
    for (int it = 0; it < 300; it++) begin
      logic [31:0] p = $urandom;
      logic [3:0] s = 4'($urandom), c = 4'($urandom);
      bus_wr(2'd0, p); m_prio = p[15:0];
      bus_wr(2'd2, {28'd0, s}); m_mask = m_mask | s;
      bus_wr(2'd3, {28'd0, c}); m_mask = m_mask & ~c;
      apply_and_check("R8 random", 4'($urandom), 4'($urandom));
      if (it % 8 == 0) begin
        bus_rd(2'd1, rv); check("R3 random", rv, {28'd0, req});
        bus_rd(2'd2, rv); check("R4 R5 random", rv, {28'd0, m_mask});
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule